// File: doc/BRIEF.md
# Floating-Point Issue Scoreboard

This block sits at the single issue point of an in-order core and decides, one instruction per cycle at most, whether the instruction presented to it may start. Each instruction carries an operation class, two source register indices and a destination register index. The classes are integer, load, single or double floating add, and single or double floating multiply. The block does no arithmetic. It models each execution resource by its timing and reports a write-back event on a dedicated port when each operation would finish.

The floating adder and the floating multiplier are not pipelined. Each is held for the whole latency of the operation it accepted, and that latency depends on the precision. Integer work, loads, one add and one multiply can all be in flight together. A pending bit per register blocks any instruction that reads or overwrites a result that is not yet complete. The bit is seen as clear in the cycle its write-back is reported, so a dependant starts with no dead cycle. An instruction that cannot start is held on the input by a valid/ready handshake.

Top module: `fp_issue_scoreboard`

## Requirements
- R1: After reset, `in_ready` is 1 and every write-back valid output is 0.
- R2: Operation codes are 0 integer, 1 load, 2 single add, 3 double add, 4 single multiply, 5 double multiply; codes 6 and 7 behave as integer. An integer instruction accepted at clock edge E reports `wb_int_vld` with its destination in the cycle right after E.
- R3: A load accepted at edge E reports on `wb_ld_*` in the cycle after edge E+2. An instruction that names the load's destination may be accepted at edge E+3 at the earliest, so the third instruction after the load does not stall.
- R4: An add of either precision holds the adder for 4 cycles. Its write-back is reported in the cycle after edge E+3, and another add is accepted no earlier than edge E+4.
- R5: A single multiply holds the multiplier for 6 cycles. Its write-back is reported in the cycle after edge E+5, and another multiply is accepted no earlier than edge E+6.
- R6: A double multiply holds the multiplier for 8 cycles. Its write-back is reported in the cycle after edge E+7, and another multiply is accepted no earlier than edge E+8.
- R7: Instructions that have no register overlap and need different units (integer or load, adder, multiplier) are accepted on consecutive edges.
- R8: An instruction whose source is the destination of an incomplete operation is held until the cycle in which that write-back is reported, and it is accepted at the edge that ends that cycle.
- R9: An instruction whose destination is still pending is held in the same way as in R8. No two write-back ports ever report the same register in one cycle.
- R10: Completions from different units in the same cycle are each reported on their own port in that cycle.
- R11: While `in_ready` is 0 or `in_valid` is 0, no instruction is taken. No write-back follows from cycles without acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction is presented |
| in_op | input | 3 | Operation class code |
| in_src_a | input | REG_W | First source register |
| in_src_b | input | REG_W | Second source register |
| in_dst | input | REG_W | Destination register |
| in_ready | output | 1 | Instruction may be accepted this cycle |
| wb_int_vld | output | 1 | Integer result completes |
| wb_int_reg | output | REG_W | Register written by integer result |
| wb_ld_vld | output | 1 | Load result completes |
| wb_ld_reg | output | REG_W | Register written by load |
| wb_add_vld | output | 1 | Floating add completes |
| wb_add_reg | output | REG_W | Register written by add |
| wb_mul_vld | output | 1 | Floating multiply completes |
| wb_mul_reg | output | REG_W | Register written by multiply |

## Verification
A wrong busy count or a stuck pending bit shows up at once as a changed acceptance edge for the next dependent or same-unit instruction. It also shows as a write-back that comes early, comes late, or is missing. The bench sweeps every ordered pair of operation classes in three register relations: independent, read-after-write and write-after-write. For each pair it compares the measured gap between acceptances and the write-back cycle against latencies it computes itself. An error in a single timer therefore fails within one trial of at most about sixteen cycles.

// File: rtl/scb_pkg.sv
package scb_pkg;

  typedef enum logic [2:0] {
    OP_INT    = 3'd0,
    OP_LOAD   = 3'd1,
    OP_FADD_S = 3'd2,
    OP_FADD_D = 3'd3,
    OP_FMUL_S = 3'd4,
    OP_FMUL_D = 3'd5
  } op_e;

  // write-back port order, shared by top and pending table
  localparam int WB_INT  = 0;
  localparam int WB_LD   = 1;
  localparam int WB_ADD  = 2;
  localparam int WB_MUL  = 3;
  localparam int NUM_WB  = 4;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/scb_unit_timer.sv
// Occupancy timer for one non-pipelined unit: loaded with the latency at
// start, counts down, reports completion when the count reaches one.
module scb_unit_timer #(
  parameter int CNT_W = 4,
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] lat_i,
  input  logic [REG_W-1:0] dst_i,
  output logic             free_o,
  output logic             wb_vld_o,
  output logic [REG_W-1:0] wb_reg_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [REG_W-1:0] dst_q;

  always_comb begin
    cnt_d = cnt_q;
    if (start_i) begin
      cnt_d = lat_i;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // destination is captured only on a start (clock enable)
  always_ff @(posedge clk) begin
    if (start_i) begin
      dst_q <= dst_i;
    end
  end

  assign free_o   = (cnt_q <= CNT_W'(1));
  assign wb_vld_o = (cnt_q == CNT_W'(1));
  assign wb_reg_o = dst_q;

  // R4/R5/R6: a unit is never restarted while it still has work to finish
  a_r4_no_restart_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> (cnt_q <= CNT_W'(1)));

  // R4/R5/R6: a completion is followed by an idle unit unless restarted
  a_r5_idle_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_vld_o && !start_i) |=> (cnt_q == '0));

endmodule

// File: rtl/scb_result_pipe.sv
// Fixed-depth pipelined result path (integer and load); each stage carries a
// valid flag and a destination index.
module scb_result_pipe #(
  parameter int DEPTH = 3,
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld_i,
  input  logic [REG_W-1:0] in_reg_i,
  output logic             out_vld_o,
  output logic [REG_W-1:0] out_reg_o
);

  logic [DEPTH-1:0] vld_q;
  logic [REG_W-1:0] reg_q [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    logic             vld_in;
    logic [REG_W-1:0] reg_in;

    if (s == 0) begin : g_head
      assign vld_in = in_vld_i;
      assign reg_in = in_reg_i;
    end else begin : g_body
      assign vld_in = vld_q[s-1];
      assign reg_in = reg_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[s] <= 1'b0;
      end else begin
        vld_q[s] <= vld_in;
      end
    end

    always_ff @(posedge clk) begin
      if (vld_in) begin
        reg_q[s] <= reg_in;
      end
    end
  end

  assign out_vld_o = vld_q[DEPTH-1];
  assign out_reg_o = reg_q[DEPTH-1];

endmodule

// File: rtl/scb_pending_table.sv
// One pending bit per register. Completions reported this cycle are treated
// as already cleared for the hazard check (same-cycle bypass).
module scb_pending_table #(
  parameter int NUM_REGS = 32,
  parameter int NUM_WB   = 4,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         set_i,
  input  logic [REG_W-1:0]             set_reg_i,
  input  logic [NUM_WB-1:0]            wb_vld_i,
  input  logic [NUM_WB-1:0][REG_W-1:0] wb_reg_i,
  input  logic [REG_W-1:0]             chk_a_i,
  input  logic [REG_W-1:0]             chk_b_i,
  input  logic [REG_W-1:0]             chk_d_i,
  output logic                         hazard_o
);

  logic [NUM_REGS-1:0] pend_q, pend_d;
  logic [NUM_REGS-1:0] clr_mask, set_mask, pend_eff;

  always_comb begin
    clr_mask = '0;
    for (int i = 0; i < NUM_WB; i++) begin
      if (wb_vld_i[i]) begin
        clr_mask[wb_reg_i[i]] = 1'b1;
      end
    end
    set_mask = '0;
    if (set_i) begin
      set_mask[set_reg_i] = 1'b1;
    end
    pend_eff = pend_q & ~clr_mask;
    pend_d   = pend_eff | set_mask;
    hazard_o = pend_eff[chk_a_i] | pend_eff[chk_b_i] | pend_eff[chk_d_i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= pend_d;
    end
  end

  // R8: every reported completion retires a register that was pending
  for (genvar i = 0; i < NUM_WB; i++) begin : g_wb_chk
    a_r8_wb_was_pending: assert property (@(posedge clk) disable iff (!rst_n)
      wb_vld_i[i] |-> pend_q[wb_reg_i[i]]);
  end

endmodule

// File: rtl/fp_issue_scoreboard.sv
module fp_issue_scoreboard
  import scb_pkg::*;
#(
  parameter int NUM_REGS  = 32,
  parameter int LOAD_LAT  = 3,
  parameter int ADD_LAT_S = 4,
  parameter int ADD_LAT_D = 4,
  parameter int MUL_LAT_S = 6,
  parameter int MUL_LAT_D = 8,
  localparam int REG_W    = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [2:0]       in_op,
  input  logic [REG_W-1:0] in_src_a,
  input  logic [REG_W-1:0] in_src_b,
  input  logic [REG_W-1:0] in_dst,
  output logic             in_ready,
  output logic             wb_int_vld,
  output logic [REG_W-1:0] wb_int_reg,
  output logic             wb_ld_vld,
  output logic [REG_W-1:0] wb_ld_reg,
  output logic             wb_add_vld,
  output logic [REG_W-1:0] wb_add_reg,
  output logic             wb_mul_vld,
  output logic [REG_W-1:0] wb_mul_reg
);

  localparam int ADD_MAX = max2(ADD_LAT_S, ADD_LAT_D);
  localparam int MUL_MAX = max2(MUL_LAT_S, MUL_LAT_D);
  localparam int ADD_CW  = $clog2(ADD_MAX + 1);
  localparam int MUL_CW  = $clog2(MUL_MAX + 1);

  // decode
  logic is_load, is_add, is_mul, is_int;
  logic [ADD_CW-1:0] add_lat;
  logic [MUL_CW-1:0] mul_lat;

  always_comb begin
    is_load = (in_op == OP_LOAD);
    is_add  = (in_op == OP_FADD_S) || (in_op == OP_FADD_D);
    is_mul  = (in_op == OP_FMUL_S) || (in_op == OP_FMUL_D);
    is_int  = !(is_load || is_add || is_mul);
    add_lat = (in_op == OP_FADD_D) ? ADD_CW'(ADD_LAT_D) : ADD_CW'(ADD_LAT_S);
    mul_lat = (in_op == OP_FMUL_D) ? MUL_CW'(MUL_LAT_D) : MUL_CW'(MUL_LAT_S);
  end

  // issue decision
  logic add_free, mul_free, hazard, unit_ok, issue;

  always_comb begin
    unit_ok  = (is_add ? add_free : 1'b1) & (is_mul ? mul_free : 1'b1);
    in_ready = unit_ok & ~hazard;
    issue    = in_valid & in_ready;
  end

  // execution resources
  scb_result_pipe #(.DEPTH(1), .REG_W(REG_W)) i_int_pipe (
    .clk(clk), .rst_n(rst_n),
    .in_vld_i(issue & is_int), .in_reg_i(in_dst),
    .out_vld_o(wb_int_vld), .out_reg_o(wb_int_reg)
  );

  scb_result_pipe #(.DEPTH(LOAD_LAT), .REG_W(REG_W)) i_ld_pipe (
    .clk(clk), .rst_n(rst_n),
    .in_vld_i(issue & is_load), .in_reg_i(in_dst),
    .out_vld_o(wb_ld_vld), .out_reg_o(wb_ld_reg)
  );

  scb_unit_timer #(.CNT_W(ADD_CW), .REG_W(REG_W)) i_add_timer (
    .clk(clk), .rst_n(rst_n),
    .start_i(issue & is_add), .lat_i(add_lat), .dst_i(in_dst),
    .free_o(add_free), .wb_vld_o(wb_add_vld), .wb_reg_o(wb_add_reg)
  );

  scb_unit_timer #(.CNT_W(MUL_CW), .REG_W(REG_W)) i_mul_timer (
    .clk(clk), .rst_n(rst_n),
    .start_i(issue & is_mul), .lat_i(mul_lat), .dst_i(in_dst),
    .free_o(mul_free), .wb_vld_o(wb_mul_vld), .wb_reg_o(wb_mul_reg)
  );

  // register hazards
  logic [NUM_WB-1:0]            wb_vld_vec;
  logic [NUM_WB-1:0][REG_W-1:0] wb_reg_vec;

  always_comb begin
    wb_vld_vec[WB_INT] = wb_int_vld;
    wb_vld_vec[WB_LD]  = wb_ld_vld;
    wb_vld_vec[WB_ADD] = wb_add_vld;
    wb_vld_vec[WB_MUL] = wb_mul_vld;
    wb_reg_vec[WB_INT] = wb_int_reg;
    wb_reg_vec[WB_LD]  = wb_ld_reg;
    wb_reg_vec[WB_ADD] = wb_add_reg;
    wb_reg_vec[WB_MUL] = wb_mul_reg;
  end

  scb_pending_table #(.NUM_REGS(NUM_REGS), .NUM_WB(NUM_WB)) i_pending (
    .clk(clk), .rst_n(rst_n),
    .set_i(issue), .set_reg_i(in_dst),
    .wb_vld_i(wb_vld_vec), .wb_reg_i(wb_reg_vec),
    .chk_a_i(in_src_a), .chk_b_i(in_src_b), .chk_d_i(in_dst),
    .hazard_o(hazard)
  );

  // R2: accepted integer work completes one cycle later with its destination
  a_r2_int_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && is_int) |=> (wb_int_vld && wb_int_reg == $past(in_dst)));

  // R9: never two completions for one register in the same cycle
  a_r9_wb_distinct: assert property (@(posedge clk) disable iff (!rst_n)
    !((wb_int_vld && wb_ld_vld  && wb_int_reg == wb_ld_reg)  ||
      (wb_int_vld && wb_add_vld && wb_int_reg == wb_add_reg) ||
      (wb_int_vld && wb_mul_vld && wb_int_reg == wb_mul_reg) ||
      (wb_ld_vld  && wb_add_vld && wb_ld_reg  == wb_add_reg) ||
      (wb_ld_vld  && wb_mul_vld && wb_ld_reg  == wb_mul_reg) ||
      (wb_add_vld && wb_mul_vld && wb_add_reg == wb_mul_reg)));

  // R11: no presented instruction, no integer completion next cycle
  a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !wb_int_vld);

endmodule

// File: tb/test_fp_issue_scoreboard.sv
module test_fp_issue_scoreboard;

  localparam int REG_W = 5;

  logic             clk;
  logic             rst_n;
  logic             in_valid;
  logic [2:0]       in_op;
  logic [REG_W-1:0] in_src_a, in_src_b, in_dst;
  logic             in_ready;
  logic             wb_int_vld, wb_ld_vld, wb_add_vld, wb_mul_vld;
  logic [REG_W-1:0] wb_int_reg, wb_ld_reg, wb_add_reg, wb_mul_reg;

  fp_issue_scoreboard i_fp_issue_scoreboard (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_op(in_op),
    .in_src_a(in_src_a), .in_src_b(in_src_b), .in_dst(in_dst),
    .in_ready(in_ready),
    .wb_int_vld(wb_int_vld), .wb_int_reg(wb_int_reg),
    .wb_ld_vld(wb_ld_vld),   .wb_ld_reg(wb_ld_reg),
    .wb_add_vld(wb_add_vld), .wb_add_reg(wb_add_reg),
    .wb_mul_vld(wb_mul_vld), .wb_mul_reg(wb_mul_reg)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int tests = 0;
  int fails = 0;
  int epoch = 0;

  // monitor: first write-back per port in the current epoch
  int first_cyc [4];
  int first_reg [4];
  int rec_epoch [4];
  int il_epoch = -1;
  int am_epoch = -1;
  int any_epoch = -1;

  initial for (int p = 0; p < 4; p++) rec_epoch[p] = -1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (wb_int_vld && rec_epoch[0] != epoch) begin
        rec_epoch[0] = epoch; first_cyc[0] = cyc; first_reg[0] = int'(wb_int_reg);
      end
      if (wb_ld_vld && rec_epoch[1] != epoch) begin
        rec_epoch[1] = epoch; first_cyc[1] = cyc; first_reg[1] = int'(wb_ld_reg);
      end
      if (wb_add_vld && rec_epoch[2] != epoch) begin
        rec_epoch[2] = epoch; first_cyc[2] = cyc; first_reg[2] = int'(wb_add_reg);
      end
      if (wb_mul_vld && rec_epoch[3] != epoch) begin
        rec_epoch[3] = epoch; first_cyc[3] = cyc; first_reg[3] = int'(wb_mul_reg);
      end
      if (wb_int_vld && wb_ld_vld)  il_epoch = epoch;
      if (wb_add_vld && wb_mul_vld) am_epoch = epoch;
      if (wb_int_vld || wb_ld_vld || wb_add_vld || wb_mul_vld) any_epoch = epoch;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  // model: latency per op code (R2..R6)
  function automatic int lat_of(input int op);
    case (op)
      0: return 1;
      1: return 3;
      2, 3: return 4;
      4: return 6;
      5: return 8;
      default: return 1;
    endcase
  endfunction

  function automatic int unit_of(input int op);   // 0 none, 1 add, 2 mul
    if (op == 2 || op == 3) return 1;
    if (op == 4 || op == 5) return 2;
    return 0;
  endfunction

  function automatic int port_of(input int op);
    if (op == 1) return 1;
    if (unit_of(op) == 1) return 2;
    if (unit_of(op) == 2) return 3;
    return 0;
  endfunction

  function automatic string req_of(input int op);
    case (op)
      0: return "R2";
      1: return "R3";
      2, 3: return "R4";
      4: return "R5";
      default: return "R6";
    endcase
  endfunction

  // called at a negedge; returns at the negedge after acceptance
  task automatic send(input int op, input int a, input int b, input int d,
                      output int acc);
    int waited = 0;
    in_valid = 1'b1;
    in_op    = 3'(op);
    in_src_a = REG_W'(a);
    in_src_b = REG_W'(b);
    in_dst   = REG_W'(d);
    acc = -1;
    while (acc < 0) begin
      #1;
      if (in_ready) begin
        acc = cyc + 1;
        @(negedge clk);
      end else begin
        waited++;
        if (waited > 40) begin
          chk(1'b0, "R11 stuck", waited, 40);
          acc = cyc;
        end
        @(negedge clk);
      end
    end
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    int acc_a, acc_b, acc_c, gap_exp, p, bs, bd;
    string rq;
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_op = '0;
    in_src_a = '0;
    in_src_b = '0;
    in_dst = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R1 reset state
    chk(in_ready == 1'b1, "R1 ready", int'(in_ready), 1);
    chk({wb_int_vld, wb_ld_vld, wb_add_vld, wb_mul_vld} == 4'b0, "R1 wb idle",
        int'({wb_int_vld, wb_ld_vld, wb_add_vld, wb_mul_vld}), 0);
    @(negedge clk);

    // sweep: ordered pairs of classes x {independent, RAW, WAW}
    for (int a = 0; a < 6; a++) begin
      for (int b = 0; b < 6; b++) begin
        for (int rel = 0; rel < 3; rel++) begin
          epoch++;
          bs = (rel == 1) ? 3 : 4;
          bd = (rel == 2) ? 3 : 6;
          send(a, 1, 2, 3, acc_a);
          send(b, bs, 5, bd, acc_b);
          idle(14);
          if (rel == 1) begin
            gap_exp = lat_of(a); rq = "R8";          // source waits for result
          end else if (rel == 2) begin
            gap_exp = lat_of(a); rq = "R9";          // destination waits
          end else if (unit_of(a) != 0 && unit_of(a) == unit_of(b)) begin
            gap_exp = lat_of(a); rq = req_of(a);     // unit occupied
          end else begin
            gap_exp = 1; rq = "R7";                  // concurrent classes
          end
          if (a == 1 && rel != 0) rq = "R3";
          chk(acc_b - acc_a == gap_exp, $sformatf("%s gap a=%0d b=%0d rel=%0d", rq, a, b, rel),
              acc_b - acc_a, gap_exp);
          p = port_of(a);
          chk(rec_epoch[p] == epoch && first_cyc[p] == acc_a + lat_of(a) - 1,
              $sformatf("%s wb cycle a=%0d b=%0d rel=%0d", req_of(a), a, b, rel),
              first_cyc[p] - acc_a, lat_of(a) - 1);
          chk(rec_epoch[p] == epoch && first_reg[p] == 3,
              $sformatf("%s wb reg a=%0d", req_of(a), a), first_reg[p], 3);
        end
      end
    end

    // R2: op codes 6 and 7 behave as integer
    for (int op = 6; op < 8; op++) begin
      epoch++;
      send(op, 1, 2, 9, acc_a);
      idle(4);
      chk(rec_epoch[0] == epoch && first_cyc[0] == acc_a && first_reg[0] == 9,
          $sformatf("R2 code %0d as integer", op), first_cyc[0] - acc_a, 0);
    end

    // R10: load and integer complete together
    epoch++;
    send(1, 1, 2, 10, acc_a);
    send(0, 1, 2, 11, acc_b);
    send(0, 1, 2, 12, acc_c);
    idle(6);
    chk(il_epoch == epoch, "R10 int+load same cycle", il_epoch, epoch);

    // R10: single multiply and double add complete together
    epoch++;
    send(4, 1, 2, 13, acc_a);
    send(0, 1, 2, 14, acc_b);
    send(3, 1, 2, 15, acc_c);
    idle(10);
    chk(am_epoch == epoch, "R10 add+mul same cycle", am_epoch, epoch);
    chk(acc_c - acc_a == 2, "R7 add under busy mul", acc_c - acc_a, 2);

    // R11: inputs change with in_valid low, no work results
    epoch++;
    in_valid = 1'b0;
    for (int k = 0; k < 12; k++) begin
      in_op = 3'(k % 6);
      in_dst = REG_W'(k + 16);
      @(negedge clk);
    end
    idle(10);
    chk(any_epoch != epoch, "R11 no wb without valid", any_epoch, epoch - 1);

    // R11: stalled instruction held; later accepted once
    epoch++;
    send(5, 1, 2, 20, acc_a);
    send(4, 1, 2, 21, acc_b);
    idle(12);
    chk(acc_b - acc_a == 8, "R11 held multiply", acc_b - acc_a, 8);
    chk(rec_epoch[3] == epoch && first_reg[3] == 20, "R6 first mul reg", first_reg[3], 20);

    summary();
    $finish;
  end

endmodule